// File: doc/BRIEF.md
# Critical-Word-First Line Fill Engine

This block sits between a cache miss handler and an AXI4 read port. When the core misses on a word, the handler presents the word address once. The engine then issues a single wrapping read burst that covers the whole cache line. The burst starts at the missed bus word, so the memory side returns the word the core is waiting for on the first beat.

Every returned beat is written into a line buffer at its wrapped position. The first beat is also handed straight to the core on its own strobe, so the core can resume while the remaining beats are still arriving. When the beat flagged as last arrives, the engine reports that the line is complete. Along with completion it reports:

- whether any beat came back with a response other than OKAY;
- whether the last flag arrived on the wrong beat.

It marks the buffered line valid only when neither error occurred. The engine handles one fill at a time. The number of beats per line must be a power of two.

Top module: `line_fill_engine`

## Requirements
- R1: One cycle after a request is accepted, ar_valid_o rises. The AR fields are:
  - ar_addr_o: the request address with its low 3 bits cleared.
  - ar_len_o: 7, the beats per line minus one.
  - ar_size_o: 3, for 8 bytes per beat.
  - ar_burst_o: 2'b10, WRAP.

  ar_valid_o and ar_addr_o stay unchanged until the cycle in which ar_ready_i is seen high.
- R2: req_ready_o is high only while no fill is in progress. It drops in the cycle after a request is accepted. It returns high in the same cycle that done_o pulses. A request presented while req_ready_o is low has no effect.
- R3: r_ready_o is high from the cycle after the AR handshake up to and including the cycle of the beat that carries r_last_i. It is low at all other times.
- R4: The start index is address bits [5:3]. Beat k of a fill is stored in slot (start index + k) mod 8. Slot i appears on line_data_o bits [64*i+63 : 64*i].
- R5: In the cycle after the first beat of a fill is accepted, crit_valid_o pulses for one cycle and crit_data_o carries that beat's data. The strobe fires only once per fill.
- R6: done_o pulses for one cycle, in the cycle after the beat that carries r_last_i is accepted.
- R7: resp_err_o rises together with done_o if any beat of the fill had r_resp_i other than 2'b00. In that case line_valid_o stays low.
- R8: line_valid_o rises together with done_o when the fill had neither a response error nor a protocol error. It clears in the cycle after the next request is accepted.
- R9: proto_err_o rises together with done_o in either of two cases:
  - r_last_i arrived on a beat other than the 8th.
  - The 8th beat lacked r_last_i. The fill then keeps accepting beats until r_last_i arrives.

  resp_err_o and proto_err_o hold their values until the next request is accepted.
- R10: While reset is held and right after it is released:
  - req_ready_o is 1.
  - ar_valid_o, r_ready_o, crit_valid_o, done_o and line_valid_o are 0.
  - line_data_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Miss request valid |
| req_ready_o | output | 1 | Engine can accept a miss request |
| req_addr_i | input | 32 | Byte address of the missed word |
| ar_valid_o | output | 1 | Read address valid |
| ar_ready_i | input | 1 | Read address ready |
| ar_addr_o | output | 32 | Read address, aligned to the bus word |
| ar_len_o | output | 8 | Burst length minus one |
| ar_size_o | output | 3 | Beat size, log2 of bytes |
| ar_burst_o | output | 2 | Burst type, WRAP |
| r_valid_i | input | 1 | Read data valid |
| r_ready_o | output | 1 | Read data ready |
| r_data_i | input | 64 | Read data beat |
| r_resp_i | input | 2 | Read response |
| r_last_i | input | 1 | Last beat of burst |
| crit_valid_o | output | 1 | Critical word strobe |
| crit_data_o | output | 64 | Critical word data |
| done_o | output | 1 | Line fill complete strobe |
| resp_err_o | output | 1 | Non-OKAY response seen during the fill |
| proto_err_o | output | 1 | Last flag on an unexpected beat |
| line_valid_o | output | 1 | Buffered line is valid |
| line_data_o | output | 512 | Line buffer, slot i at bits 64*i upward |

## Verification
Every result is registered, so each one is due exactly one cycle after the edge that causes it:

| Cause (accepted at a rising edge) | Result, one cycle later |
|---|---|
| Request | AR valid appears |
| AR handshake | Read ready opens |
| First beat | Critical-word strobe |
| Beat with the last flag | Completion, error flags and valid line |

The bench keeps a behavioural model whose state advances on the same rising edge as the design, from the same sampled inputs. It compares every output on the following falling edge, so each expected value is checked in the exact cycle it is due rather than within a window. Stimulus changes only on falling edges. The handshakes therefore resolve at the next rising edge and need no assumption about process order.

// File: rtl/lfe_pkg.sv
package lfe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } lfe_state_e;

  localparam logic [1:0] BURST_WRAP = 2'b10;
  localparam logic [1:0] RESP_OKAY  = 2'b00;
endpackage

// File: rtl/lfe_addr_gen.sv
module lfe_addr_gen #(
  parameter int ADDR_W   = 32,
  parameter int SIZE_LOG = 3,
  parameter int IDX_W    = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] aligned_o,
  output logic [IDX_W-1:0]  start_idx_o
);
  assign aligned_o   = {addr_i[ADDR_W-1:SIZE_LOG], {SIZE_LOG{1'b0}}};
  // word index inside the line = first beat's slot
  assign start_idx_o = addr_i[SIZE_LOG +: IDX_W];
endmodule

// File: rtl/lfe_line_buf.sv
module lfe_line_buf #(
  parameter int DATA_W = 64,
  parameter int BEATS  = 8,
  parameter int IDX_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [IDX_W-1:0]        wr_slot_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  output logic [BEATS*DATA_W-1:0] line_o
);
  logic [BEATS-1:0] wr_vec;

  for (genvar g = 0; g < BEATS; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    assign wr_vec[g] = wr_en_i && (wr_slot_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        slot_q <= '0;
      else if (wr_vec[g]) slot_q <= wr_data_i;
    end
    assign line_o[g*DATA_W +: DATA_W] = slot_q;
  end

  AST_ONE_SLOT_PER_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wr_vec) == (wr_en_i ? 1 : 0)); // R4
endmodule

// File: rtl/lfe_ctrl.sv
module lfe_ctrl
  import lfe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BEATS  = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] aligned_i,
  input  logic [IDX_W-1:0]  start_idx_i,
  output logic              ar_valid_o,
  input  logic              ar_ready_i,
  output logic [ADDR_W-1:0] ar_addr_o,
  input  logic              r_valid_i,
  output logic              r_ready_o,
  input  logic [1:0]        r_resp_i,
  input  logic              r_last_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_slot_o,
  output logic              crit_take_o,
  output logic              crit_stb_o,
  output logic              done_o,
  output logic              resp_err_o,
  output logic              proto_err_o,
  output logic              line_valid_o
);
  lfe_state_e        state_q;
  logic [IDX_W-1:0]  start_q, cnt_q;
  logic              first_q, eacc_q, pacc_q;
  logic              accept, beat, beat_bad_resp, beat_bad_last, fin;

  assign req_ready_o = (state_q == ST_IDLE);
  assign ar_valid_o  = (state_q == ST_ADDR);
  assign r_ready_o   = (state_q == ST_DATA);

  assign accept        = req_valid_i && req_ready_o;
  assign beat          = r_valid_i && r_ready_o;
  assign beat_bad_resp = (r_resp_i != RESP_OKAY);
  assign beat_bad_last = r_last_i != (cnt_q == IDX_W'(BEATS-1));
  assign fin           = beat && r_last_i;

  assign wr_en_o     = beat;
  assign wr_slot_o   = start_q + cnt_q; // wraps mod BEATS
  assign crit_take_o = beat && first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      ar_addr_o    <= '0;
      start_q      <= '0;
      cnt_q        <= '0;
      first_q      <= 1'b0;
      eacc_q       <= 1'b0;
      pacc_q       <= 1'b0;
      crit_stb_o   <= 1'b0;
      done_o       <= 1'b0;
      resp_err_o   <= 1'b0;
      proto_err_o  <= 1'b0;
      line_valid_o <= 1'b0;
    end else begin
      crit_stb_o <= crit_take_o;
      done_o     <= fin;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q      <= ST_ADDR;
          ar_addr_o    <= aligned_i;
          start_q      <= start_idx_i;
          cnt_q        <= '0;
          first_q      <= 1'b1;
          eacc_q       <= 1'b0;
          pacc_q       <= 1'b0;
          resp_err_o   <= 1'b0;
          proto_err_o  <= 1'b0;
          line_valid_o <= 1'b0;
        end
        ST_ADDR: if (ar_ready_i) state_q <= ST_DATA;
        ST_DATA: if (beat) begin
          cnt_q   <= cnt_q + 1'b1;
          first_q <= 1'b0;
          eacc_q  <= eacc_q | beat_bad_resp;
          pacc_q  <= pacc_q | beat_bad_last;
          if (r_last_i) begin
            state_q      <= ST_IDLE;
            resp_err_o   <= eacc_q | beat_bad_resp;
            proto_err_o  <= pacc_q | beat_bad_last;
            line_valid_o <= !(eacc_q | beat_bad_resp | pacc_q | beat_bad_last);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_AR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_valid_o && !ar_ready_i |=> ar_valid_o && $stable(ar_addr_o)); // R1
  AST_READY_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o && !r_ready_o); // R2
  AST_RREADY_AFTER_AR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(r_ready_o) |-> $past(ar_valid_o && ar_ready_i)); // R3
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(r_valid_i && r_ready_o && r_last_i)); // R6
  AST_CRIT_AFTER_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_stb_o |-> $past(r_valid_i && r_ready_o)); // R5
  AST_CLEAN_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_valid_o) |-> done_o && !resp_err_o && !proto_err_o); // R8
  AST_ERR_BLOCKS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_err_o |-> !line_valid_o); // R7
endmodule

// File: rtl/line_fill_engine.sv
module line_fill_engine
  import lfe_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int LINE_BYTES = 64,
  localparam int BUS_BYTES = DATA_W / 8,
  localparam int BEATS     = LINE_BYTES / BUS_BYTES,
  localparam int IDX_W     = $clog2(BEATS),
  localparam int SIZE_LOG  = $clog2(BUS_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [ADDR_W-1:0]       req_addr_i,
  output logic                    ar_valid_o,
  input  logic                    ar_ready_i,
  output logic [ADDR_W-1:0]       ar_addr_o,
  output logic [7:0]              ar_len_o,
  output logic [2:0]              ar_size_o,
  output logic [1:0]              ar_burst_o,
  input  logic                    r_valid_i,
  output logic                    r_ready_o,
  input  logic [DATA_W-1:0]       r_data_i,
  input  logic [1:0]              r_resp_i,
  input  logic                    r_last_i,
  output logic                    crit_valid_o,
  output logic [DATA_W-1:0]       crit_data_o,
  output logic                    done_o,
  output logic                    resp_err_o,
  output logic                    proto_err_o,
  output logic                    line_valid_o,
  output logic [BEATS*DATA_W-1:0] line_data_o
);
  logic [ADDR_W-1:0] aligned;
  logic [IDX_W-1:0]  start_idx, wr_slot;
  logic              wr_en, crit_take;

  assign ar_len_o   = 8'(BEATS - 1);
  assign ar_size_o  = 3'(SIZE_LOG);
  assign ar_burst_o = BURST_WRAP;

  lfe_addr_gen #(.ADDR_W(ADDR_W), .SIZE_LOG(SIZE_LOG), .IDX_W(IDX_W)) u_addr (
    .addr_i      (req_addr_i),
    .aligned_o   (aligned),
    .start_idx_o (start_idx)
  );

  lfe_ctrl #(.ADDR_W(ADDR_W), .BEATS(BEATS), .IDX_W(IDX_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .aligned_i    (aligned),
    .start_idx_i  (start_idx),
    .ar_valid_o   (ar_valid_o),
    .ar_ready_i   (ar_ready_i),
    .ar_addr_o    (ar_addr_o),
    .r_valid_i    (r_valid_i),
    .r_ready_o    (r_ready_o),
    .r_resp_i     (r_resp_i),
    .r_last_i     (r_last_i),
    .wr_en_o      (wr_en),
    .wr_slot_o    (wr_slot),
    .crit_take_o  (crit_take),
    .crit_stb_o   (crit_valid_o),
    .done_o       (done_o),
    .resp_err_o   (resp_err_o),
    .proto_err_o  (proto_err_o),
    .line_valid_o (line_valid_o)
  );

  lfe_line_buf #(.DATA_W(DATA_W), .BEATS(BEATS), .IDX_W(IDX_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_slot_i (wr_slot),
    .wr_data_i (r_data_i),
    .line_o    (line_data_o)
  );

  // critical word bypasses the buffer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        crit_data_o <= '0;
    else if (crit_take) crit_data_o <= r_data_i;
  end

  AST_CRIT_MATCHES_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_valid_o |-> crit_data_o == line_data_o[$past(wr_slot)*DATA_W +: DATA_W]); // R5
endmodule

// File: tb/line_fill_engine_bench.sv
module line_fill_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic        ar_valid, ar_ready = 1'b0;
  logic [31:0] ar_addr;
  logic [7:0]  ar_len;
  logic [2:0]  ar_size;
  logic [1:0]  ar_burst;
  logic        r_valid = 1'b0, r_ready, r_last = 1'b0;
  logic [63:0] r_data = '0;
  logic [1:0]  r_resp = '0;
  logic        crit_valid, done, resp_err, proto_err, line_valid;
  logic [63:0] crit_data;
  logic [511:0] line_data;

  line_fill_engine u_line_fill_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .ar_valid_o(ar_valid), .ar_ready_i(ar_ready), .ar_addr_o(ar_addr),
    .ar_len_o(ar_len), .ar_size_o(ar_size), .ar_burst_o(ar_burst),
    .r_valid_i(r_valid), .r_ready_o(r_ready), .r_data_i(r_data),
    .r_resp_i(r_resp), .r_last_i(r_last),
    .crit_valid_o(crit_valid), .crit_data_o(crit_data), .done_o(done),
    .resp_err_o(resp_err), .proto_err_o(proto_err),
    .line_valid_o(line_valid), .line_data_o(line_data)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model: 0 idle, 1 address, 2 data
  int          m_st = 0, m_cnt = 0, m_start = 0;
  bit          m_crit = 0, m_done = 0, m_lv = 0, m_err = 0, m_perr = 0, m_eacc = 0, m_pacc = 0;
  logic [31:0] m_araddr = '0;
  logic [63:0] m_crit_data = '0;
  logic [63:0] m_line [8];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_crit = 0; m_done = 0; m_lv = 0; m_err = 0; m_perr = 0;
      m_crit_data = '0; m_araddr = '0;
      foreach (m_line[i]) m_line[i] = '0;
    end else begin
      m_crit = 0; m_done = 0;
      if (m_st == 0) begin
        if (req_valid) begin
          m_araddr = req_addr & ~32'h7;
          m_start = int'(req_addr[5:3]);
          m_cnt = 0; m_eacc = 0; m_pacc = 0;
          m_lv = 0; m_err = 0; m_perr = 0;
          m_st = 1;
        end
      end else if (m_st == 1) begin
        if (ar_ready) m_st = 2;
      end else if (r_valid) begin
        m_line[(m_start + m_cnt) % 8] = r_data;
        if (m_cnt == 0) begin m_crit = 1; m_crit_data = r_data; end
        if (r_resp != 2'b00) m_eacc = 1;
        if (r_last != ((m_cnt % 8) == 7)) m_pacc = 1;
        m_cnt++;
        if (r_last) begin
          m_done = 1; m_err = m_eacc; m_perr = m_pacc;
          m_lv = !(m_eacc || m_pacc);
          m_st = 0;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(req_ready == (m_st == 0), "R2 req_ready", 64'(req_ready), 64'(m_st == 0));
    chk(ar_valid == (m_st == 1), "R1 ar_valid", 64'(ar_valid), 64'(m_st == 1));
    if (ar_valid) begin
      chk(ar_addr == m_araddr, "R1 ar_addr", 64'(ar_addr), 64'(m_araddr));
      chk(ar_len == 8'd7 && ar_size == 3'd3 && ar_burst == 2'b10, "R1 ar_fields",
          64'({ar_len, ar_size, ar_burst}), 64'({8'd7, 3'd3, 2'b10}));
    end
    chk(r_ready == (m_st == 2), "R3 r_ready", 64'(r_ready), 64'(m_st == 2));
    chk(crit_valid == m_crit, "R5 crit_valid", 64'(crit_valid), 64'(m_crit));
    if (m_crit) chk(crit_data == m_crit_data, "R5 crit_data", crit_data, m_crit_data);
    chk(done == m_done, "R6 done", 64'(done), 64'(m_done));
    chk(resp_err == m_err, "R7 resp_err", 64'(resp_err), 64'(m_err));
    chk(proto_err == m_perr, "R9 proto_err", 64'(proto_err), 64'(m_perr));
    chk(line_valid == m_lv, "R8 line_valid", 64'(line_valid), 64'(m_lv));
    if (m_done) for (int i = 0; i < 8; i++)
      chk(line_data[i*64 +: 64] == m_line[i], "R4 line slot", line_data[i*64 +: 64], m_line[i]);
  end

  int fill_no = 0;

  task automatic fill(input logic [31:0] a, input int ar_dly, input int gap,
                      input int err_beat, input int nbeats, input bit hold_req);
    int st;
    logic [31:0] base;
    st = int'(a[5:3]);
    base = a & ~32'h3f;
    fill_no++;
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    if (hold_req) req_addr = a ^ 32'h0000_0128; // R2: ignored while busy
    else req_valid = 1'b0;
    repeat (ar_dly) @(negedge clk);
    ar_ready = 1'b1;
    @(negedge clk); ar_ready = 1'b0;
    for (int k = 0; k < nbeats; k++) begin
      repeat (gap) @(negedge clk);
      r_valid = 1'b1;
      r_data  = {32'(fill_no), base + 32'(((st + k) % 8) * 8)};
      r_resp  = (k == err_beat) ? 2'b10 : 2'b00;
      r_last  = (k == nbeats - 1);
      if (k == nbeats - 1 && hold_req) req_valid = 1'b0;
      @(negedge clk);
      r_valid = 1'b0; r_last = 1'b0; r_resp = 2'b00;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state while held
    chk(req_ready == 1'b1, "R10 req_ready", 64'(req_ready), 64'd1);
    chk(!ar_valid && !r_ready && !crit_valid && !done && !line_valid, "R10 outputs low",
        64'({ar_valid, r_ready, crit_valid, done, line_valid}), 64'd0);
    chk(line_data == '0, "R10 line zero", line_data[63:0], 64'd0);
    rst_n = 1'b1;
    fill(32'h0000_1000, 0, 0, -1, 8, 0);   // start slot 0
    fill(32'h0000_1038, 3, 1, -1, 8, 0);   // start slot 7, AR stall, gaps
    fill(32'h0000_2013, 1, 2, -1, 8, 1);   // unaligned, request held while busy
    fill(32'h0000_3028, 0, 0, 4, 8, 0);    // R7 error response on beat 4
    fill(32'h0000_4008, 0, 0, -1, 8, 0);   // clean again, valid restored
    fill(32'h0000_5030, 2, 0, -1, 6, 0);   // R9 early last
    fill(32'h0000_6018, 0, 1, -1, 10, 0);  // R9 late last, slots wrap again
    fill(32'h0000_7020, 0, 0, 0, 8, 1);    // R7 error on the critical beat
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule